// File: doc/BRIEF.md
# Codec Loopback Test-Mode Controller

This block sits on the host side of an isolated telephone-line codec and decides where the sample returned to the data pump comes from. Samples from the data pump enter on `dp_din` once per sample-rate strobe. They pass through a one-stage filter stand-in and go out toward the isolation link on `link_tx`. Each strobe the block drives `dp_dout` from one of three sources: line-side receive data (`link_rx`), its own filtered input, or a copy of the transmit stream returned over a link stand-in.

A small register interface holds the control bits. The line-side power-down bit is set at reset, so the block comes up in start-up loopback and needs no line-side power. Clearing that bit switches the output to live receive data and raises a link-up status bit. Three further test modes are digital loopback, analog loopback and internal analog loopback (hybrid off). They take effect only after the line is off-hook and a calibration count of sample strobes has completed. A request made earlier waits until the count finishes. More than one request at a time is refused. Going on-hook or powering the line side down again cancels the test mode and restarts calibration.

Top module: `lbk_test_ctrl`

## Requirements
- R1: After reset the control word at address 0 reads 0x11 (power-down and hybrid-enable set, all else clear). The status word reads 0x08: start-up mode, link-up clear, calibration not done.
- R2: With power-down set (control bit 0), each strobe captures `dp_din` into the filter stage, which is visible on `link_tx`. The sample captured at strobe k appears on `dp_dout` after strobe k+1.
- R3: In normal mode (status mode code 0) each strobe loads `link_rx` into `dp_dout`, with a latency of one strobe.
- R4: Status bit 0 (link-up) sets at the first strobe with power-down clear. It clears on the clock after power-down is set again.
- R5: The calibration count advances by one per strobe while off-hook (control bit 1) is set and power-down is clear, and holds at CAL_LEN. Status bit 1 (calibration done) reads 1 once the count equals CAL_LEN.
- R6: A test request (control bit 2 digital, bit 3 analog, bit 4 cleared for hybrid off) made before calibration is done leaves the mode normal. It takes effect in the cycle the count reaches CAL_LEN.
- R7: In digital loopback (mode code 2) the sample captured at strobe k appears on `dp_dout` after strobe k+2.
- R8: In analog loopback (mode code 3) `ls_ana_lb` is 1, `ls_hyb_off` is 0, and `dp_dout` carries `link_rx` as in R3.
- R9: In internal analog loopback (mode code 4, hybrid-enable cleared) `ls_hyb_off` is 1, `ls_ana_lb` is 0, and `dp_dout` carries `link_rx`.
- R10: With two or more requests active, status bit 2 (conflict) is 1, the mode is normal, and neither `ls_ana_lb` nor `ls_hyb_off` is asserted.
- R11: Clearing off-hook or setting power-down drops any test mode at once (to normal, or to start-up when powered down), clears the count and clears calibration done.
- R12: Address 0 reads back the control word {hybrid-enable, analog, digital, off-hook, power-down} in bits 4..0. Address 1 returns {mode code in bits 5..3, conflict, calibration done, link-up}. Writes go to address 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_stb | input | 1 | Sample-rate strobe, one clock wide |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | 5 | Control word write data |
| cfg_rdata | output | 8 | Register read data |
| dp_din | input | W | Sample from the data pump |
| dp_dout | output | W | Sample returned to the data pump |
| link_tx | output | W | Filtered sample toward the isolation link |
| link_rx | input | W | Receive sample from the line side |
| ls_pwr_dn | output | 1 | Line side power-down control |
| ls_ana_lb | output | 1 | Line side analog loopback enable |
| ls_hyb_off | output | 1 | Line side hybrid disable (internal loopback) |

## Verification
The transmit side carries a ramp, an alternating 0xAAAA/0x5555 word and a scrambled sequence. The receive side carries a different sequence, so no output value can be explained by the wrong source. The ramp shows the latency of each path: a one-strobe error in start-up or digital loopback returns a neighbour value. The alternating word catches a path that swaps or drops strobes. The scrambled data separates the filter path from the link-return path, and either of them from receive data. The calibration run holds a pending request through the full count, so the exact switch-over cycle is compared as well.

// File: rtl/lbk_test_ctrl.sv
module lbk_test_ctrl #(
  parameter int W       = 16,
  parameter int CAL_LEN = 4608,
  parameter int AW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_stb,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [4:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [W-1:0]  dp_din,
  output logic [W-1:0]  dp_dout,
  output logic [W-1:0]  link_tx,
  input  logic [W-1:0]  link_rx,
  output logic          ls_pwr_dn,
  output logic          ls_ana_lb,
  output logic          ls_hyb_off
);
  localparam int CW = $clog2(CAL_LEN + 1);
  localparam logic [2:0] M_NORM = 3'd0, M_START = 3'd1, M_DIG = 3'd2,
                         M_ANA = 3'd3, M_INT = 3'd4;

  logic pwr_dn, off_hook, dl_req, al_req, hyb_en, link_up;
  logic [CW-1:0] cal_cnt;
  logic [W-1:0]  in_q, lb_q;
  logic [2:0]    mode, req;
  logic          conflict, cal_done;

  assign req      = {dl_req, al_req, ~hyb_en};
  assign conflict = $countones(req) > 1;
  assign cal_done = cal_cnt == CW'(CAL_LEN);

  always_comb begin
    if (pwr_dn)                                   mode = M_START;
    else if (!cal_done || conflict || req == '0)  mode = M_NORM;
    else if (dl_req)                              mode = M_DIG;
    else if (al_req)                              mode = M_ANA;
    else                                          mode = M_INT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hyb_en, al_req, dl_req, off_hook, pwr_dn} <= 5'b10001;
    end else if (cfg_we && cfg_addr == AW'(0)) begin
      {hyb_en, al_req, dl_req, off_hook, pwr_dn} <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cal_cnt <= '0;
    else if (!off_hook || pwr_dn)    cal_cnt <= '0;
    else if (fs_stb && !cal_done)    cal_cnt <= cal_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      link_up <= 1'b0;
    else if (pwr_dn) link_up <= 1'b0;
    else if (fs_stb) link_up <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q    <= '0;
      lb_q    <= '0;
      dp_dout <= '0;
    end else if (fs_stb) begin
      in_q <= dp_din;
      lb_q <= in_q;
      case (mode)
        M_START: dp_dout <= in_q;
        M_DIG:   dp_dout <= lb_q;
        default: dp_dout <= link_rx;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      AW'(0):  cfg_rdata = {3'b000, hyb_en, al_req, dl_req, off_hook, pwr_dn};
      AW'(1):  cfg_rdata = {2'b00, mode, conflict, cal_done, link_up};
      default: cfg_rdata = 8'h00;
    endcase
  end

  assign link_tx    = in_q;
  assign ls_pwr_dn  = pwr_dn;
  assign ls_ana_lb  = mode == M_ANA;
  assign ls_hyb_off = mode == M_INT;
endmodule

// File: rtl/lbk_test_ctrl_chk.sv
module lbk_test_ctrl_chk #(
  parameter int W       = 16,
  parameter int CAL_LEN = 4608
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              fs_stb,
  input logic                              pwr_dn,
  input logic                              off_hook,
  input logic [$clog2(CAL_LEN + 1)-1:0]    cal_cnt,
  input logic                              conflict,
  input logic [2:0]                        mode,
  input logic                              link_up,
  input logic [W-1:0]                      dp_dout,
  input logic [W-1:0]                      link_rx,
  input logic                              ls_ana_lb,
  input logic                              ls_hyb_off
);
  localparam int CW = $clog2(CAL_LEN + 1);

  AST_CAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 || mode == 3'd3 || mode == 3'd4) |-> cal_cnt == CW'(CAL_LEN)); // R6
  AST_NORMAL_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && mode == 3'd0) |=> dp_dout == $past(link_rx)); // R3
  AST_LINK_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && !pwr_dn) |=> link_up); // R4
  AST_LINK_UP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> !link_up); // R4
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!off_hook || pwr_dn) |=> cal_cnt == '0); // R11
  AST_CONFLICT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !pwr_dn) |-> mode == 3'd0); // R10
  AST_LS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ls_ana_lb, ls_hyb_off})); // R10
endmodule

bind lbk_test_ctrl lbk_test_ctrl_chk #(.W(W), .CAL_LEN(CAL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .pwr_dn(pwr_dn),
  .off_hook(off_hook), .cal_cnt(cal_cnt), .conflict(conflict), .mode(mode),
  .link_up(link_up), .dp_dout(dp_dout), .link_rx(link_rx),
  .ls_ana_lb(ls_ana_lb), .ls_hyb_off(ls_hyb_off)
);

// File: tb/test_lbk_test_ctrl.sv
module test_lbk_test_ctrl;
  localparam int W = 16, CAL = 4608, SP = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, fs_stb = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [4:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [W-1:0] dp_din = '0, link_rx = '0, dp_dout, link_tx;
  logic ls_pwr_dn, ls_ana_lb, ls_hyb_off;

  lbk_test_ctrl #(.W(W), .CAL_LEN(CAL), .AW(2)) i_lbk_test_ctrl (
    .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .dp_din(dp_din), .dp_dout(dp_dout), .link_tx(link_tx), .link_rx(link_rx),
    .ls_pwr_dn(ls_pwr_dn), .ls_ana_lb(ls_ana_lb), .ls_hyb_off(ls_hyb_off));

  int vecs = 0, bad = 0, cyc = 0;
  bit done = 0;
  int m_pd = 1, m_oh = 0, m_dl = 0, m_al = 0, m_hyb = 1, m_cnt = 0, m_lu = 0;
  logic [W-1:0] hist[$];
  logic [W-1:0] m_dout = '0;

  function automatic int m_mode();
    int n = m_dl + m_al + (m_hyb ? 0 : 1);
    if (m_pd != 0) return 1;
    if (m_cnt < CAL || n != 1) return 0;
    if (m_dl != 0) return 2;
    if (m_al != 0) return 3;
    return 4;
  endfunction

  function automatic int m_rdata(input int a);
    int md = m_mode();
    int cf = (m_dl + m_al + (m_hyb ? 0 : 1)) > 1 ? 1 : 0;
    if (a == 0) return m_pd | (m_oh << 1) | (m_dl << 2) | (m_al << 3) | (m_hyb << 4);
    if (a == 1) return m_lu | ((m_cnt == CAL ? 1 : 0) << 1) | (cf << 2) | (md << 3);
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int md = m_mode();
    chk(tag, "dp_dout", int'(dp_dout), int'(m_dout));
    chk(tag, "link_tx", int'(link_tx), int'(hist[0]));
    chk(tag, "ls_pwr_dn", int'(ls_pwr_dn), m_pd);
    chk(tag, "ls_ana_lb", int'(ls_ana_lb), md == 3 ? 1 : 0);
    chk(tag, "ls_hyb_off", int'(ls_hyb_off), md == 4 ? 1 : 0);
    chk(tag, "cfg_rdata", int'(cfg_rdata), m_rdata(int'(cfg_addr)));
  endtask

  task automatic model_step();
    int md = m_mode();
    if (fs_stb) begin
      if (md == 1)      m_dout = hist[0];
      else if (md == 2) m_dout = hist[1];
      else              m_dout = link_rx;
      hist.push_front(dp_din);
      void'(hist.pop_back());
    end
    if (m_pd != 0) m_lu = 0; else if (fs_stb) m_lu = 1;
    if (m_oh == 0 || m_pd != 0) m_cnt = 0;
    else if (fs_stb && m_cnt < CAL) m_cnt++;
    if (cfg_we && cfg_addr == 2'd0) begin
      m_pd = cfg_wdata[0]; m_oh = cfg_wdata[1]; m_dl = cfg_wdata[2];
      m_al = cfg_wdata[3]; m_hyb = cfg_wdata[4];
    end
  endtask

  task automatic tick(input string tag);
    fs_stb = (cyc % SP) == 0;
    model_step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check_all(tag);
  endtask

  task automatic drive(input int pat);
    case (pat)
      0: dp_din = W'(cyc * 7);
      1: dp_din = (cyc % 2 == 0) ? 16'hAAAA : 16'h5555;
      default: dp_din = W'((cyc * 40503) ^ (cyc >> 3));
    endcase
    link_rx = W'(~(cyc * 13 + 16'h3C00));
  endtask

  task automatic run(input int n, input int pat, input string tag);
    for (int i = 0; i < n; i++) begin
      drive(pat);
      tick(tag);
    end
  endtask

  task automatic wr(input logic [4:0] v, input string tag);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = v;
    drive(2);
    tick(tag);
    cfg_we = 1'b0; cfg_addr = 2'd1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    hist.push_back('0);
    hist.push_back('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "ctrl reset", int'(cfg_rdata), 32'h11);
    chk("R1", "dp_dout reset", int'(dp_dout), 0);
    cfg_addr = 2'd1;
    #1;
    chk("R1", "status reset", int'(cfg_rdata), 32'h08);
    @(negedge clk);

    run(30, 0, "R2");
    run(30, 1, "R2");
    run(30, 2, "R2");

    wr(5'h10, "R12");
    run(30, 2, "R3");
    run(6, 0, "R4");

    wr(5'h14, "R12");
    run(30, 0, "R6");
    wr(5'h16, "R6");
    run(CAL * SP - 12, 2, "R5");
    run(20, 2, "R6");
    run(30, 0, "R7");
    run(30, 1, "R7");

    wr(5'h1A, "R8");
    run(30, 2, "R8");
    wr(5'h02, "R9");
    run(30, 2, "R9");
    wr(5'h0E, "R10");
    run(30, 2, "R10");
    wr(5'h1E, "R10");
    run(30, 2, "R10");

    wr(5'h16, "R7");
    run(15, 0, "R7");
    wr(5'h14, "R11");
    run(15, 0, "R11");
    wr(5'h16, "R11");
    run(15, 0, "R11");
    wr(5'h17, "R11");
    run(15, 0, "R11");
    run(6, 0, "R4");

    cfg_addr = 2'd0;
    run(4, 1, "R12");
    cfg_addr = 2'd2;
    run(4, 1, "R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule